// File: doc/BRIEF.md
# Mixed-Polarity Toffoli Cascade Evaluator

This block computes a reversible Boolean function of an n-bit state. The function is built from a stored list of generalized Toffoli gates. Each gate marks every state line with one of four roles: the line it flips (the target), a line that must be 1, a line that must be 0, or a line that plays no part. The target line flips only when every control line holds its required value. A gate with no controls flips its target unconditionally. A small register bank holds one descriptor per gate, and a count register says how many of the leading descriptors form the cascade.

Software loads the descriptors and the count first. It then presents an input vector and pulses `start`. The engine applies one gate per clock cycle and signals `done` when the last gate has been applied. The cascade can run in forward order (gate 0 first) or in reverse order (last active gate first). Each gate is its own inverse, so the reverse order computes the inverse permutation. A descriptor that does not hold exactly one target acts as the identity, and the engine reports it with a flag that accompanies `done`.

Top module: `toffoli_cascade`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `done` and `bad_gate` are 0 and `dout` is all zeros.
- R2: Line i of a gate occupies descriptor bits [2i+1:2i], with role code 0 = target, 1 = must-be-1 control, 2 = must-be-0 control, 3 = ignored. A gate with exactly one target XORs its target line with the AND of its control literals.
- R3: A must-be-1 control line that holds 0 leaves the state unchanged.
- R4: A must-be-0 control line that holds 1 leaves the state unchanged.
- R5: An ignored line never changes and never affects whether the target flips.
- R6: A gate with one target and no control lines inverts its target for every input.
- R7: A descriptor with zero or with two or more targets leaves the state unchanged. `bad_gate` is then 1 in the `done` cycle of that run, and it is 0 in the `done` cycle of a run with only legal gates.
- R8: In forward order, gates 0 to count-1 are applied in ascending order, one per cycle. `done` is high for one cycle, in the cycle that follows the (count+1)-th rising edge, counting the edge that sampled `start`. With count 0, `dout` equals `din` at `done`.
- R9: In reverse order, gates count-1 down to 0 are applied. A reverse run on the output of a forward run over the same cascade returns the original input.
- R10: A `start` pulse while `busy` is high is ignored. The run in progress completes with its original input and direction.
- R11: Descriptor and count writes while `busy` is high are discarded. Neither the run in progress nor later runs see them.
- R12: In every cycle while `busy` is high, at most one bit of `dout` changes on the next edge. While idle with no `start`, `dout` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_we | input | 1 | Write strobe for one gate descriptor |
| desc_addr | input | IDX_W | Gate slot to write |
| desc_data | input | 2*LINES | Descriptor, two role bits per line |
| count_we | input | 1 | Write strobe for the active gate count |
| count_data | input | CNT_W | Number of active gates, clamped to DEPTH |
| start | input | 1 | Begin a run with `din` and `reverse` |
| reverse | input | 1 | 1 runs the cascade from the last active gate down to gate 0 |
| din | input | LINES | Input state vector |
| busy | output | 1 | Gates are being applied |
| done | output | 1 | One-cycle pulse: `dout` holds the result |
| bad_gate | output | 1 | With `done`: the run met an illegal descriptor |
| dout | output | LINES | Current state, and the result at `done` |

## Verification
The controller can receive a new `start` or a configuration write in the same cycle that it is stepping through gates. It can also receive them in the cycle that it retires the last gate. The bench provokes both. It pulses `start` with a different vector and direction one cycle into a run. It also rewrites a descriptor and the count while a run is in progress. It judges the outcome by comparing `dout` at `done` with the result computed for the untouched cascade, and by rerunning afterwards to confirm that the stored configuration did not change. A sweep over all 256 single-gate descriptors against all 16 inputs covers every role combination.

// File: rtl/tgc_pkg.sv
// Shared role codes for the Toffoli cascade evaluator.
// Assumes two bits per line in each descriptor.
package tgc_pkg;
    typedef enum logic [1:0] {
        ROLE_TARGET = 2'd0,
        ROLE_POS    = 2'd1,
        ROLE_NEG    = 2'd2,
        ROLE_IGNORE = 2'd3
    } line_role_e;
endpackage

// File: rtl/tgc_desc_bank.sv
// Register bank of gate descriptors with one write port and one read port.
// Assumes the controller blocks writes while a run is active (wr_block).
// Reset fills every slot with the all-ignored pattern.
module tgc_desc_bank #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_block,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_val
);
    logic [DW-1:0] slots [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        // Purpose: hold one descriptor, updated only when idle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[k] <= '1;
            end else if (wr_en && !wr_block && (wr_idx == IDX_W'(k))) begin
                slots[k] <= wr_val;
            end
        end
    end

    // Purpose: present the descriptor of the gate being applied.
    always_comb begin
        rd_val = slots[rd_idx];
    end
endmodule

// File: rtl/tgc_gate_apply.sv
// Combinational evaluation of one mixed-polarity Toffoli gate.
// Assumes the role code order of tgc_pkg. An illegal descriptor passes the state through.
module tgc_gate_apply
    import tgc_pkg::*;
#(
    parameter int LINES = 4
) (
    input  logic [2*LINES-1:0] desc,
    input  logic [LINES-1:0]   cur,
    output logic [LINES-1:0]   nxt,
    output logic               illegal
);
    logic [LINES-1:0] tgt_mask;
    logic [LINES-1:0] blocked;
    logic             fire;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_role_e role;
        // Purpose: classify one line and test its control literal.
        always_comb begin
            role        = line_role_e'(desc[2*g +: 2]);
            tgt_mask[g] = (role == ROLE_TARGET);
            blocked[g]  = ((role == ROLE_POS) && !cur[g]) ||
                          ((role == ROLE_NEG) &&  cur[g]);
        end
    end

    // Purpose: check the single-target rule and flip the target if unblocked.
    always_comb begin
        illegal = ($countones(tgt_mask) != 1);
        fire    = !illegal && !(|blocked);
        nxt     = fire ? (cur ^ tgt_mask) : cur;
    end
endmodule

// File: rtl/tgc_sequencer.sv
// Run controller: holds the state vector and gate count and steps through the gates.
// Assumes the next-state and legality come from tgc_gate_apply on the addressed slot.
module tgc_sequencer #(
    parameter int LINES = 4,
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_we,
    input  logic [CNT_W-1:0] count_data,
    input  logic             start,
    input  logic             reverse,
    input  logic [LINES-1:0] din,
    input  logic [LINES-1:0] gate_nxt,
    input  logic             gate_bad,
    output logic [IDX_W-1:0] gate_idx,
    output logic [LINES-1:0] state,
    output logic             busy,
    output logic             done,
    output logic             bad_flag
);
    logic [CNT_W-1:0] gcount;
    logic [CNT_W-1:0] left;
    logic             backward;
    logic             bad_acc;

    // Purpose: keep the active gate count, clamped and frozen during a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcount <= '0;
        end else if (count_we && !busy) begin
            gcount <= (count_data > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : count_data;
        end
    end

    // Purpose: accept start, apply one gate per cycle, pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= '0;
            gate_idx <= '0;
            left     <= '0;
            backward <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            bad_acc  <= 1'b0;
            bad_flag <= 1'b0;
        end else begin
            done     <= 1'b0;
            bad_flag <= 1'b0;
            if (!busy) begin
                if (start) begin
                    state    <= din;
                    backward <= reverse;
                    bad_acc  <= 1'b0;
                    left     <= gcount;
                    gate_idx <= reverse ? IDX_W'(gcount - 1'b1) : '0;
                    if (gcount == '0) begin
                        done <= 1'b1;
                    end else begin
                        busy <= 1'b1;
                    end
                end
            end else begin
                state    <= gate_nxt;
                bad_acc  <= bad_acc | gate_bad;
                left     <= left - 1'b1;
                gate_idx <= backward ? (gate_idx - 1'b1) : (gate_idx + 1'b1);
                if (left == CNT_W'(1)) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    bad_flag <= bad_acc | gate_bad;
                end
            end
        end
    end
endmodule

// File: rtl/toffoli_cascade.sv
// Top level: descriptor bank, gate evaluator and run controller.
// Assumes LINES <= 8 and DEPTH <= 32. One gate is applied per clock.
module toffoli_cascade #(
    parameter int LINES = 4,
    parameter int DEPTH = 16,
    localparam int DW    = 2 * LINES,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_we,
    input  logic [IDX_W-1:0] desc_addr,
    input  logic [DW-1:0]    desc_data,
    input  logic             count_we,
    input  logic [CNT_W-1:0] count_data,
    input  logic             start,
    input  logic             reverse,
    input  logic [LINES-1:0] din,
    output logic             busy,
    output logic             done,
    output logic             bad_gate,
    output logic [LINES-1:0] dout
);
    logic [IDX_W-1:0] gate_idx;
    logic [DW-1:0]    cur_desc;
    logic [LINES-1:0] gate_nxt;
    logic             gate_bad;

    tgc_desc_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (desc_we),
        .wr_block (busy),
        .wr_idx   (desc_addr),
        .wr_val   (desc_data),
        .rd_idx   (gate_idx),
        .rd_val   (cur_desc)
    );

    tgc_gate_apply #(.LINES(LINES)) u_gate (
        .desc    (cur_desc),
        .cur     (dout),
        .nxt     (gate_nxt),
        .illegal (gate_bad)
    );

    tgc_sequencer #(.LINES(LINES), .DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_we   (count_we),
        .count_data (count_data),
        .start      (start),
        .reverse    (reverse),
        .din        (din),
        .gate_nxt   (gate_nxt),
        .gate_bad   (gate_bad),
        .gate_idx   (gate_idx),
        .state      (dout),
        .busy       (busy),
        .done       (done),
        .bad_flag   (bad_gate)
    );
endmodule

// File: rtl/tgc_checks.sv
// Port-level properties of the cascade evaluator, bound to the top module.
module tgc_checks #(
    parameter int LINES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             bad_gate,
    input logic [LINES-1:0] dout
);
    a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    a_r7_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        bad_gate |-> done);

    a_r12_one_line_per_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($countones(dout ^ $past(dout)) <= 1));

    a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(dout));
endmodule

bind toffoli_cascade tgc_checks #(.LINES(LINES)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .bad_gate (bad_gate),
    .dout     (dout)
);

// File: tb/toffoli_cascade_test.sv
`timescale 1ns/1ps
module toffoli_cascade_test;
    localparam int N  = 4;
    localparam int D  = 16;
    localparam int IW = 4;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          desc_we = 1'b0;
    logic [IW-1:0] desc_addr = '0;
    logic [2*N-1:0] desc_data = '0;
    logic          count_we = 1'b0;
    logic [CW-1:0] count_data = '0;
    logic          start = 1'b0;
    logic          reverse = 1'b0;
    logic [N-1:0]  din = '0;
    logic          busy, done, bad_gate;
    logic [N-1:0]  dout;

    int n_chk = 0;
    int n_bad = 0;
    logic [2*N-1:0] casc [D];

    always #10 clk = ~clk;

    toffoli_cascade #(.LINES(N), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .desc_we(desc_we), .desc_addr(desc_addr),
        .desc_data(desc_data), .count_we(count_we), .count_data(count_data),
        .start(start), .reverse(reverse), .din(din), .busy(busy), .done(done),
        .bad_gate(bad_gate), .dout(dout));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Spec model of one gate: returns {illegal, next_state}.
    function automatic logic [N:0] gate_model(input logic [2*N-1:0] d, input logic [N-1:0] s);
        int ntgt = 0;
        logic ok = 1'b1;
        logic [N-1:0] flip = '0;
        for (int i = 0; i < N; i++) begin
            int r = int'(d[2*i +: 2]);
            if (r == 0) begin ntgt++; flip[i] = 1'b1; end
            if (r == 1 && s[i] == 1'b0) ok = 1'b0;
            if (r == 2 && s[i] == 1'b1) ok = 1'b0;
        end
        if (ntgt != 1) return {1'b1, s};
        return {1'b0, ok ? (s ^ flip) : s};
    endfunction

    function automatic logic [N-1:0] casc_model(input logic [N-1:0] s, input int cnt, input logic rv);
        logic [N-1:0] v = s;
        for (int j = 0; j < cnt; j++) begin
            logic [N:0] r = gate_model(casc[rv ? (cnt - 1 - j) : j], v);
            v = r[N-1:0];
        end
        return v;
    endfunction

    task automatic put_desc(input int a, input logic [2*N-1:0] v);
        desc_we = 1'b1; desc_addr = IW'(a); desc_data = v;
        @(negedge clk);
        desc_we = 1'b0;
    endtask

    task automatic put_count(input int c);
        count_we = 1'b1; count_data = CW'(c);
        @(negedge clk);
        count_we = 1'b0;
    endtask

    task automatic run(input logic [N-1:0] x, input logic rv,
                       output logic [N-1:0] y, output logic b, output int cyc);
        din = x; reverse = rv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        y = dout; b = bad_gate;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [N-1:0] y, y2;
        logic b;
        int cyc;
        logic [N:0] m;
        logic [15:0] lfsr = 16'hACE1;

        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 bad_gate", int'(bad_gate), 0);
        chk("R1 dout", int'(dout), 0);

        // R8: empty cascade passes input through, done after the start edge.
        run(4'hA, 1'b0, y, b, cyc);
        chk("R8 count0 latency", cyc, 1);
        chk("R8 count0 dout", int'(y), 'hA);

        // Exhaustive single-gate sweep: R2..R7.
        put_count(1);
        for (int d = 0; d < 256; d++) begin
            put_desc(0, 8'(d));
            for (int s = 0; s < 16; s++) begin
                m = gate_model(8'(d), 4'(s));
                run(4'(s), 1'b0, y, b, cyc);
                if (m[N]) begin
                    chk("R7 illegal identity", int'(y), int'(m[N-1:0]));
                    chk("R7 flag set", int'(b), 1);
                end else begin
                    chk("R2 gate result", int'(y), int'(m[N-1:0]));
                    chk("R7 flag clear", int'(b), 0);
                end
            end
        end

        // Directed role cases.
        put_desc(0, 8'b11_11_01_00);    // target line0, must-be-1 on line1
        run(4'b0000, 1'b0, y, b, cyc);
        chk("R3 pos ctl blocks", int'(y), 'b0000);
        run(4'b0010, 1'b0, y, b, cyc);
        chk("R2 pos ctl passes", int'(y), 'b0011);
        put_desc(0, 8'b11_11_10_00);    // must-be-0 on line1
        run(4'b0010, 1'b0, y, b, cyc);
        chk("R4 neg ctl blocks", int'(y), 'b0010);
        run(4'b0000, 1'b0, y, b, cyc);
        chk("R4 neg ctl passes", int'(y), 'b0001);
        put_desc(0, 8'b11_11_11_00);    // no controls, ignored lines 1..3
        for (int s = 0; s < 16; s++) begin
            run(4'(s), 1'b0, y, b, cyc);
            chk("R6 unconditional flip", int'(y), s ^ 1);
            chk("R5 ignored lines hold", int'(y[3:1]), s >> 1);
        end

        // Random legal cascade of D gates.
        for (int j = 0; j < D; j++) begin
            logic [2*N-1:0] v;
            for (int i = 0; i < N; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                v[2*i +: 2] = (lfsr[1:0] == 2'b00) ? 2'b11 : lfsr[1:0];
            end
            v[2*(j % N) +: 2] = 2'b00;
            casc[j] = v;
            put_desc(j, v);
        end
        put_count(D);
        for (int s = 0; s < 16; s++) begin
            run(4'(s), 1'b0, y, b, cyc);
            chk("R8 forward cascade", int'(y), int'(casc_model(4'(s), D, 1'b0)));
            chk("R8 forward latency", cyc, D + 1);
            run(y, 1'b1, y2, b, cyc);
            chk("R9 reverse restores", int'(y2), s);
            run(4'(s), 1'b1, y2, b, cyc);
            chk("R9 reverse order", int'(y2), int'(casc_model(4'(s), D, 1'b1)));
        end

        put_count(5);
        run(4'h6, 1'b0, y, b, cyc);
        chk("R8 count5 latency", cyc, 6);
        chk("R8 count5 result", int'(y), int'(casc_model(4'h6, 5, 1'b0)));

        // R10: start during busy ignored.
        put_count(D);
        din = 4'h3; reverse = 1'b0; start = 1'b1;
        @(negedge clk);
        din = 4'hC; reverse = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 2;
        while (!done && cyc < 200) begin @(negedge clk); cyc++; end
        chk("R10 restart ignored", int'(dout), int'(casc_model(4'h3, D, 1'b0)));
        chk("R10 latency kept", cyc, D + 1);

        // R11: writes during busy discarded.
        din = 4'h9; reverse = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        desc_we = 1'b1; desc_addr = '0; desc_data = 8'b11_11_11_00 ^ casc[0];
        count_we = 1'b1; count_data = CW'(1);
        @(negedge clk);
        desc_we = 1'b0; count_we = 1'b0;
        cyc = 2;
        while (!done && cyc < 200) begin @(negedge clk); cyc++; end
        chk("R11 run unaffected", int'(dout), int'(casc_model(4'h9, D, 1'b0)));
        run(4'h9, 1'b0, y, b, cyc);
        chk("R11 count kept", cyc, D + 1);
        chk("R11 desc kept", int'(y), int'(casc_model(4'h9, D, 1'b0)));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule